// File: doc/BRIEF.md
# Parallel OTP Memory Read Controller

This block sits on the host side of an asynchronous parallel bus to a 128K x 16 one-time-programmable memory. A host issues a read request with a 17-bit word address, or an identification request whose address bit 0 picks the manufacturer word (0) or the device word (1). The controller drives the address and the active-low chip enable together. It holds the active-low output enable back by the slack that the enable-to-data budget leaves. It keeps output enable low for the output-enable access budget and registers the data word on the last edge of that window. Only then does it release both enables. It returns the word with a one-cycle valid pulse and waits out the bus float time before it accepts the next request.

Every timing budget is given in nanoseconds through parameters. The controller turns each budget into a clock-cycle count by rounding up, with at least one cycle for each. An identification read is marked by a separate select output, and the address bus then carries zero on every bit except bit 0.

Top module: `otp_read_ctrl`

## Requirements
- R1: During and right after reset, `ready` is 1, `mem_ce_n` and `mem_oe_n` are 1, `rvalid` is 0 and `mem_id_sel` is 0.
- R2: On the clock cycle after a request is accepted, `mem_ce_n` goes to 0 with the request address on `mem_addr`. `mem_oe_n` stays 1 for exactly LEAD cycles of low chip enable, where LEAD = max(1, max(ACC, CE) - OE). The address does not change while chip enable is low, and `mem_oe_n` is never 0 while `mem_ce_n` is 1.
- R3: `mem_oe_n` stays 0 for exactly OE cycles, and `rdata` takes the value of `mem_dq` sampled on the clock edge that ends that window.
- R4: `mem_ce_n` and `mem_oe_n` both return to 1 in the cycle after the capture edge. In that same cycle `rvalid` is 1, for exactly one cycle.
- R5: After the enables rise, `ready` stays 0 for 1 + DF cycles, so chip enable stays high for at least the float time before the next access.
- R6: For an identification request (`id_mode` = 1), `mem_addr` is {16 zeros, addr[0]} and `mem_id_sel` is 1 while chip enable is low. For a normal request, `mem_addr` equals `addr` and `mem_id_sel` stays 0.
- R7: A request made while `ready` is 0 is ignored. It changes neither the bus address nor the result, and it produces no extra `rvalid`.
- R8: ACC, CE, OE and DF are the nanosecond budgets divided by `CLK_PERIOD_NS` and rounded up, with a minimum of 1. With an 8 ns clock and 55/55/20/20 ns budgets this gives 7, 7, 3 and 3, so LEAD is 4.
- R9: `rdata` keeps the last captured word until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Read request, taken when `ready` is 1 |
| ready | output | 1 | Controller is idle and can accept a request |
| addr | input | 17 | Word address of the request |
| id_mode | input | 1 | 1 selects an identification read |
| rdata | output | 16 | Captured data word |
| rvalid | output | 1 | One-cycle pulse: `rdata` is new |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_id_sel | output | 1 | Identification-mode select to the memory |
| mem_dq | input | 16 | Memory data bus |

## Verification
The bench uses a memory model that returns unknown data until all three access budgets, measured from the real address, chip-enable and output-enable edges, have run out. A controller that captures one cycle early, or that drops output enable together with chip enable, therefore returns X instead of the word. The model also flags any chip-enable fall inside the float window after the previous release, which catches a short turnaround count. Requests held high while the controller is busy check that a design accepting outside idle would disturb the address bus or return a surplus word. Identification reads with address bits set above bit 0 check that a design without masking would put a nonzero upper address on the bus.

// File: rtl/otp_rd_pkg.sv
`timescale 1ns/1ps
package otp_rd_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_OE_WAIT,
        ST_ACCESS,
        ST_CAPTURE,
        ST_FLOAT
    } rd_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              id;
    } rd_cmd_t;

    // nanoseconds to whole cycles, rounded up, never below one
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    // cycles of low chip enable before output enable may fall
    function automatic int oe_lead(input int acc, input int ce, input int oe);
        int m;
        m = (acc > ce) ? acc : ce;
        return (m - oe < 1) ? 1 : (m - oe);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/otp_rd_timer.sv
`timescale 1ns/1ps
module otp_rd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/otp_rd_seq.sv
`timescale 1ns/1ps
module otp_rd_seq
    import otp_rd_pkg::*;
#(
    parameter int LEAD_CYC = 4,
    parameter int OE_CYC   = 3,
    parameter int DF_CYC   = 3,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             tmr_zero,
    output rd_state_e        state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             cap_en
);
    localparam int OEW_LOAD = (LEAD_CYC > 1) ? (LEAD_CYC - 2) : 0;
    localparam int ACC_LOAD = OE_CYC - 1;
    localparam int FLT_LOAD = DF_CYC - 1;

    rd_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        cap_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (LEAD_CYC > 1) begin
                    state_d = ST_OE_WAIT;
                    tmr_val = CNT_W'(OEW_LOAD);
                end else begin
                    state_d = ST_ACCESS;
                    tmr_val = CNT_W'(ACC_LOAD);
                end
            end
            ST_OE_WAIT: begin
                if (tmr_zero) begin
                    state_d  = ST_ACCESS;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ACC_LOAD);
                end
            end
            ST_ACCESS: begin
                if (tmr_zero) begin
                    cap_en   = 1'b1;
                    state_d  = ST_CAPTURE;
                    tmr_load = 1'b1;
                end
            end
            ST_CAPTURE: begin
                state_d  = ST_FLOAT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(FLT_LOAD);
            end
            ST_FLOAT: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/otp_rd_datapath.sv
`timescale 1ns/1ps
module otp_rd_datapath
    import otp_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  rd_cmd_t           cmd_in,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] bus_data,
    output rd_cmd_t           cmd_q,
    output logic [DATA_W-1:0] data_q
);
    rd_cmd_t cmd_n;

    // identification reads keep only the code-select bit
    always_comb begin
        cmd_n = cmd_in;
        if (cmd_in.id) begin
            cmd_n.addr = {{(ADDR_W-1){1'b0}}, cmd_in.addr[0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                cmd_q <= cmd_n;
            end
            if (cap_en) begin
                data_q <= bus_data;
            end
        end
    end
endmodule

// File: rtl/otp_read_ctrl.sv
`timescale 1ns/1ps
module otp_read_ctrl
    import otp_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_ACC_NS      = 55,
    parameter int T_CE_NS       = 55,
    parameter int T_OE_NS       = 20,
    parameter int T_DF_NS       = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    output logic              ready,
    input  logic [ADDR_W-1:0] addr,
    input  logic              id_mode,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_id_sel,
    input  logic [DATA_W-1:0] mem_dq
);
    localparam int ACC_CYC  = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
    localparam int CE_CYC   = ns_to_cyc(T_CE_NS, CLK_PERIOD_NS);
    localparam int OE_CYC   = ns_to_cyc(T_OE_NS, CLK_PERIOD_NS);
    localparam int DF_CYC   = ns_to_cyc(T_DF_NS, CLK_PERIOD_NS);
    localparam int LEAD_CYC = oe_lead(ACC_CYC, CE_CYC, OE_CYC);
    localparam int MAX_DUR  = max3(LEAD_CYC, OE_CYC, DF_CYC);
    localparam int CNT_W    = (MAX_DUR < 2) ? 1 : $clog2(MAX_DUR + 1);

    rd_state_e        state;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             accept;
    logic             cap_en;
    rd_cmd_t          cmd_in;
    rd_cmd_t          cmd_q;
    logic             ce_active;

    otp_rd_seq #(
        .LEAD_CYC (LEAD_CYC),
        .OE_CYC   (OE_CYC),
        .DF_CYC   (DF_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .tmr_zero (tmr_zero),
        .state    (state),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .accept   (accept),
        .cap_en   (cap_en)
    );

    otp_rd_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign cmd_in.addr = addr;
    assign cmd_in.id   = id_mode;

    otp_rd_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .cmd_in   (cmd_in),
        .cap_en   (cap_en),
        .bus_data (mem_dq),
        .cmd_q    (cmd_q),
        .data_q   (rdata)
    );

    assign ce_active  = (state == ST_SETUP) || (state == ST_OE_WAIT) ||
                        (state == ST_ACCESS);
    assign mem_ce_n   = ~ce_active;
    assign mem_oe_n   = (state != ST_ACCESS);
    assign mem_id_sel = cmd_q.id & ce_active;
    assign mem_addr   = cmd_q.addr;
    assign ready      = (state == ST_IDLE);
    assign rvalid     = (state == ST_CAPTURE);
endmodule

// File: rtl/otp_read_ctrl_chk.sv
`timescale 1ns/1ps
module otp_read_ctrl_chk
    import otp_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_DF_NS       = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              rvalid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_id_sel,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int DF_CYC = ns_to_cyc(T_DF_NS, CLK_PERIOD_NS);

    logic [7:0] high_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_gap <= 8'hFF;
        end else if (!mem_ce_n) begin
            high_gap <= '0;
        end else if (high_gap != 8'hFF) begin
            high_gap <= high_gap + 8'd1;
        end
    end

    p_oe_within_ce_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    p_ctrl_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> ($rose(mem_oe_n) && rvalid));

    p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    p_float_gap_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> (int'(high_gap) >= DF_CYC + 1));

    p_id_addr_r6: assert property (@(posedge clk) disable iff (rst)
        mem_id_sel |-> (mem_addr[ADDR_W-1:1] == '0));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_ce_n && !mem_id_sel && !rvalid));
endmodule

bind otp_read_ctrl otp_read_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_DF_NS       (T_DF_NS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .rvalid     (rvalid),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_id_sel (mem_id_sel),
    .mem_addr   (mem_addr)
);

// File: tb/otp_read_ctrl_bench.sv
`timescale 1ns/1ps
module otp_read_ctrl_bench;
    localparam int  CLK_PERIOD = 8;
    localparam real T_ACC = 55.0;
    localparam real T_CE  = 55.0;
    localparam real T_OE  = 20.0;
    localparam real T_DF  = 20.0;
    localparam real TOL   = 0.5;
    localparam logic [15:0] ID_MFR = 16'h00A7;
    localparam logic [15:0] ID_DEV = 16'hC21F;
    // expected cycle counts from the requirements (R8): ceil(ns/8)
    localparam int EXP_ACC  = (55 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_OE   = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_DF   = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_LEAD = EXP_ACC - EXP_OE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [16:0] addr = '0;
    logic        id_mode = 1'b0;
    logic        ready, rvalid, mem_ce_n, mem_oe_n, mem_id_sel;
    logic [15:0] rdata;
    logic [16:0] mem_addr;
    logic [15:0] mem_dq;

    int n_checks = 0;
    int n_fail   = 0;
    int n_rvalid = 0;
    int n_push   = 0;
    logic [15:0] last_word = '0;

    typedef struct {
        logic [15:0] data;
        logic [16:0] bus_addr;
        logic        id;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    otp_read_ctrl #(.CLK_PERIOD_NS(CLK_PERIOD)) u_otp_read_ctrl (
        .clk(clk), .rst(rst), .req(req), .ready(ready), .addr(addr),
        .id_mode(id_mode), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_id_sel(mem_id_sel), .mem_dq(mem_dq)
    );

    function automatic logic [15:0] mem_word(input logic [16:0] a);
        return {a[7:0], a[15:8]} ^ {15'h0, a[16]} ^ 16'h6B1D;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    realtime t_addr = 0.0, t_ce = 0.0, t_oe = 0.0, t_off = -1000.0;

    always @(mem_addr or mem_id_sel) t_addr = $realtime;
    always @(negedge mem_oe_n) t_oe = $realtime;
    always @(posedge mem_ce_n or posedge mem_oe_n) t_off = $realtime;
    always @(negedge mem_ce_n) begin
        // R5: no new access inside the float window
        chk(($realtime - t_off) >= T_DF, "R5 float overlap",
            32'($rtoi($realtime - t_off)), 32'($rtoi(T_DF)));
        t_ce = $realtime;
    end

    initial begin
        mem_dq = 'z;
        #0.25;
        forever begin
            if (!mem_ce_n && !mem_oe_n) begin
                if (($realtime - t_addr >= T_ACC - TOL) &&
                    ($realtime - t_ce >= T_CE - TOL) &&
                    ($realtime - t_oe >= T_OE - TOL))
                    mem_dq = mem_id_sel ? (mem_addr[0] ? ID_DEV : ID_MFR)
                                        : mem_word(mem_addr);
                else
                    mem_dq = 'x;
            end else begin
                mem_dq = ($realtime - t_off < T_DF) ? 16'hxxxx : 16'hzzzz;
            end
            #0.5;
        end
    end

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            n_rvalid++;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7 unexpected rvalid", 32'(rdata), 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rdata === e.data, e.id ? "R6 id data" : "R3 read data",
                    32'(rdata), 32'(e.data));
                last_word = e.data;
            end
        end
    end

    // ---------------- bus timing monitor ----------------
    int lead_cnt = 0, oe_cnt = 0, gap_cnt = 0;
    bit in_gap = 1'b0;
    logic ce_q = 1'b1, oe_q = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n && ce_q) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R7 access without request", 32'(mem_addr), 32'h0);
                end else begin
                    chk(mem_addr == sb_q[0].bus_addr, "R6 bus address",
                        32'(mem_addr), 32'(sb_q[0].bus_addr));
                    chk(mem_id_sel == sb_q[0].id, "R6 id select",
                        32'(mem_id_sel), 32'(sb_q[0].id));
                end
            end
            if (!mem_ce_n && mem_oe_n) lead_cnt++;
            if (!mem_oe_n) begin
                if (oe_q) chk(lead_cnt == EXP_LEAD, "R2 R8 oe lead",
                              32'(lead_cnt), 32'(EXP_LEAD));
                oe_cnt++;
            end
            if (mem_oe_n && !oe_q) begin
                chk(oe_cnt == EXP_OE, "R3 R8 oe width", 32'(oe_cnt), 32'(EXP_OE));
                chk(mem_ce_n && rvalid, "R4 release with rvalid",
                    {30'h0, mem_ce_n, rvalid}, 32'h3);
                oe_cnt = 0;
                lead_cnt = 0;
                in_gap = 1'b1;
                gap_cnt = 0;
            end
            if (in_gap) begin
                if (ready) begin
                    chk(gap_cnt == EXP_DF + 1, "R5 R8 turnaround",
                        32'(gap_cnt), 32'(EXP_DF + 1));
                    in_gap = 1'b0;
                end else begin
                    gap_cnt++;
                end
            end
            ce_q = mem_ce_n;
            oe_q = mem_oe_n;
        end
    end

    // ---------------- driver ----------------
    task automatic do_read(input logic [16:0] a, input logic id, input int poke);
        exp_t e;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1;
        addr = a;
        id_mode = id;
        e.id = id;
        e.bus_addr = id ? {16'h0, a[0]} : a;
        e.data = id ? (a[0] ? ID_DEV : ID_MFR) : mem_word(a);
        sb_q.push_back(e);
        n_push++;
        @(negedge clk);
        // R7: keep requesting a different word while busy
        for (int i = 0; i < poke; i++) begin
            addr = ~a;
            id_mode = ~id;
            chk(!ready && mem_addr == e.bus_addr, "R7 busy request ignored",
                32'(mem_addr), 32'(e.bus_addr));
            @(negedge clk);
        end
        req = 1'b0;
        id_mode = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((sb_q.size() != 0 || !ready) && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(ready && mem_ce_n && mem_oe_n && !rvalid && !mem_id_sel,
            "R1 state in reset",
            {27'h0, ready, mem_ce_n, mem_oe_n, rvalid, mem_id_sel}, 32'h1C);
        rst = 1'b0;
        @(negedge clk);
        chk(ready && mem_ce_n && mem_oe_n && !rvalid && !mem_id_sel,
            "R1 state after reset",
            {27'h0, ready, mem_ce_n, mem_oe_n, rvalid, mem_id_sel}, 32'h1C);

        do_read(17'h00000, 1'b0, 0);
        do_read(17'h1FFFF, 1'b0, 0);
        do_read(17'h0AAAA, 1'b0, 3);
        do_read(17'h15555, 1'b0, 6);
        do_read(17'h12344, 1'b1, 0);
        do_read(17'h1FFFF, 1'b1, 2);
        do_read(17'h00F0F, 1'b0, 0);
        do_read(17'h10001, 1'b1, 0);
        drain();

        // R9: the last word stays on rdata while idle
        repeat (5) @(negedge clk);
        chk(rdata === last_word, "R9 rdata held", 32'(rdata), 32'(last_word));
        chk(n_rvalid == n_push, "R7 rvalid count", 32'(n_rvalid), 32'(n_push));
        chk(sb_q.size() == 0, "R4 scoreboard empty", 32'(sb_q.size()), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule